// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block keeps the transfer address and remaining transfer count of a single DMA channel. Software loads a 16-bit start address, a 16-bit count (transfers minus one), an 8-bit page byte and an 8-bit upper-page byte through a byte-wide write port. Each accepted transfer strobe moves the address forward by one unit and takes one off the count. The block presents the resulting 32-bit physical address, a one-cycle terminal-count pulse, the channel mask state, and the residue in bytes.

Two address mappings are supported, chosen by the `word_mode` input. In byte mode the 16-bit counter forms the low 16 address bits. In word mode it forms bits 16:1, bit 0 is held at zero, and the lowest page bit is unused. Unless the upper-page byte has been written since the last page write, the counter wraps inside its 64 KB (byte) or 128 KB (word) window. Once the upper-page byte has been written, a carry out of the counter advances the page and upper-page bytes together. When the count runs out, the channel either reloads its start values (`auto_init` high) or masks itself.

Top module: `dma_addr_engine`

## Requirements
- R1: After a synchronous reset the channel is masked, all address, count and page state is zero, full 32-bit carry mode is off and `tc` is low. The reset residue is therefore 1 in byte mode.
- R2: In byte mode `phys_addr[23:16]` is the page byte and `phys_addr[15:0]` is the current address counter.
- R3: In word mode `phys_addr[23:17]` is page bits 7:1, `phys_addr[16:1]` is the current address counter and `phys_addr[0]` is 0. Page bit 0 has no effect on the address.
- R4: `phys_addr[31:24]` is always the upper-page byte.
- R5: Without full 32-bit carry mode, a transfer at counter value 0xFFFF wraps the counter to 0x0000 and leaves the page and upper-page bytes unchanged.
- R6: Writing the upper-page byte turns on full 32-bit carry mode. In that mode a transfer at counter value 0xFFFF adds 1 (byte mode) or 2 (word mode) to the combined {upper-page, page} value.
- R7: Writing the page byte turns full 32-bit carry mode off.
- R8: Each accepted transfer decrements the current count modulo 2^16. `tc` is high for exactly the cycle after the transfer that took the count from 0x0000 to 0xFFFF.
- R9: `residue` equals (count + 1) mod 2^16 in byte mode and twice that value in word mode.
- R10: On the terminal transfer with `auto_init` high, the current address and count reload from their start copies and the mask stays clear. With `auto_init` low, the mask is set.
- R11: A transfer strobe has no effect while the channel is masked, and no effect in a cycle that also carries a register write.
- R12: The `wr_sel` codes are: 0 = address low byte, 1 = address high byte, 2 = count low byte, 3 = count high byte, 4 = page, 5 = upper page, 6 = mask (`wr_data[0]` becomes the mask). An address or count byte write loads both the start copy and the current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select code |
| wr_data | input | 8 | Write data byte |
| xfer | input | 1 | Transfer strobe, one per transfer |
| word_mode | input | 1 | 1 = word mapping, 0 = byte mapping |
| auto_init | input | 1 | Reload start values at terminal count |
| phys_addr | output | 32 | Physical address of the current transfer |
| tc | output | 1 | Terminal-count pulse |
| residue | output | 17 | Remaining bytes |
| masked | output | 1 | Channel mask state |

## Verification
The hardest case to reach from the ports is a counter carry in full 32-bit mode that lands on the same transfer as terminal count, or that happens just after a page write has turned that mode off again. The stimulus loads the address at 0xFFFE or 0xFFFF with a short count. It writes page and upper page in both orders, so the same boundary crossing is seen once wrapping and once carrying, in both mappings. A behavioural model built from integer arithmetic follows every cycle and is compared against all outputs on every clock.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;
  typedef enum logic [2:0] {
    SEL_ADDR_LO = 3'd0,
    SEL_ADDR_HI = 3'd1,
    SEL_CNT_LO  = 3'd2,
    SEL_CNT_HI  = 3'd3,
    SEL_PAGE    = 3'd4,
    SEL_HPAGE   = 3'd5,
    SEL_MASK    = 3'd6
  } reg_sel_e;
endpackage

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr
  import dma_eng_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CNT_W   = 16,
  parameter int PAGE_W  = 8,
  parameter int HPAGE_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [2:0]         wr_sel,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               step,
  input  logic               reload,
  input  logic               word_mode,
  output logic [CNT_W-1:0]   cur_addr,
  output logic [PAGE_W-1:0]  page,
  output logic [HPAGE_W-1:0] hpage,
  output logic               hi32
);
  localparam int NLANE = CNT_W / DATA_W;
  localparam int PW    = HPAGE_W + PAGE_W;

  logic [CNT_W-1:0] base_addr;
  logic [NLANE-1:0] lane_we;
  logic             carry;
  logic [PW-1:0]    page_sum;

  // one write strobe per byte lane of the address counter
  for (genvar b = 0; b < NLANE; b++) begin : g_lane
    assign lane_we[b] = wr_en && (wr_sel == 3'(int'(SEL_ADDR_LO) + b));
  end

  assign carry    = step && !reload && hi32 && (&cur_addr);
  assign page_sum = {hpage, page} + (word_mode ? PW'(2) : PW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr <= '0;
      cur_addr  <= '0;
    end else if (|lane_we) begin
      for (int b = 0; b < NLANE; b++) begin
        if (lane_we[b]) begin
          base_addr[b*DATA_W +: DATA_W] <= wr_data;
          cur_addr[b*DATA_W +: DATA_W]  <= wr_data;
        end
      end
    end else if (reload) begin
      cur_addr <= base_addr;
    end else if (step) begin
      cur_addr <= cur_addr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      page  <= '0;
      hpage <= '0;
      hi32  <= 1'b0;
    end else if (wr_en && wr_sel == SEL_PAGE) begin
      page <= wr_data[PAGE_W-1:0];
      hi32 <= 1'b0;
    end else if (wr_en && wr_sel == SEL_HPAGE) begin
      hpage <= wr_data[HPAGE_W-1:0];
      hi32  <= 1'b1;
    end else if (carry) begin
      {hpage, page} <= page_sum;
    end
  end

  assert_page_held_R5: assert property (@(posedge clk) disable iff (rst)
    (step && !hi32) |=> ($stable(page) && $stable(hpage)));

  assert_pagewr_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_PAGE) |=> !hi32);

  assert_hpagewr_sets_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_HPAGE) |=> hi32);
endmodule

// File: rtl/dma_cnt_unit.sv
module dma_cnt_unit
  import dma_eng_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              step,
  input  logic              reload,
  input  logic              word_mode,
  output logic [CNT_W-1:0]  cur_cnt,
  output logic              at_zero,
  output logic              tc,
  output logic [CNT_W:0]    residue
);
  localparam int NLANE = CNT_W / DATA_W;

  logic [CNT_W-1:0] base_cnt;
  logic [NLANE-1:0] lane_we;
  logic [CNT_W-1:0] left;

  for (genvar b = 0; b < NLANE; b++) begin : g_lane
    assign lane_we[b] = wr_en && (wr_sel == 3'(int'(SEL_CNT_LO) + b));
  end

  assign at_zero = (cur_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_cnt <= '0;
      cur_cnt  <= '0;
      tc       <= 1'b0;
    end else begin
      tc <= step && at_zero;
      if (|lane_we) begin
        for (int b = 0; b < NLANE; b++) begin
          if (lane_we[b]) begin
            base_cnt[b*DATA_W +: DATA_W] <= wr_data;
            cur_cnt[b*DATA_W +: DATA_W]  <= wr_data;
          end
        end
      end else if (reload) begin
        cur_cnt <= base_cnt;
      end else if (step) begin
        cur_cnt <= cur_cnt - 1'b1;
      end
    end
  end

  // transfers minus one is stored; residue wraps at 16 bits, bytes in word mode
  assign left    = cur_cnt + 1'b1;
  assign residue = word_mode ? {left, 1'b0} : {1'b0, left};

  assert_tc_only_from_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (step && !at_zero) |=> !tc);

  assert_tc_on_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (step && at_zero) |=> tc);
endmodule

// File: rtl/dma_addr_map.sv
module dma_addr_map #(
  parameter int CNT_W   = 16,
  parameter int PAGE_W  = 8,
  parameter int HPAGE_W = 8,
  localparam int ADDR_W = HPAGE_W + PAGE_W + CNT_W
) (
  input  logic               word_mode,
  input  logic [CNT_W-1:0]   cur_addr,
  input  logic [PAGE_W-1:0]  page,
  input  logic [HPAGE_W-1:0] hpage,
  output logic [ADDR_W-1:0]  phys_addr
);
  logic [ADDR_W-1:0] byte_map;
  logic [ADDR_W-1:0] word_map;

  assign byte_map  = {hpage, page, cur_addr};
  assign word_map  = {hpage, page[PAGE_W-1:1], cur_addr, 1'b0};
  assign phys_addr = word_mode ? word_map : byte_map;
endmodule

// File: rtl/dma_addr_engine.sv
module dma_addr_engine
  import dma_eng_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CNT_W   = 16,
  parameter int PAGE_W  = 8,
  parameter int HPAGE_W = 8,
  localparam int ADDR_W = HPAGE_W + PAGE_W + CNT_W,
  localparam int RES_W  = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              xfer,
  input  logic              word_mode,
  input  logic              auto_init,
  output logic [ADDR_W-1:0] phys_addr,
  output logic              tc,
  output logic [RES_W-1:0]  residue,
  output logic              masked
);
  logic               step;
  logic               last;
  logic               reload;
  logic               at_zero;
  logic [CNT_W-1:0]   cur_addr;
  logic [CNT_W-1:0]   cur_cnt;
  logic [PAGE_W-1:0]  page;
  logic [HPAGE_W-1:0] hpage;
  logic               hi32;

  // a register write in the same cycle wins over the transfer strobe
  assign step   = xfer && !masked && !wr_en;
  assign last   = step && at_zero;
  assign reload = last && auto_init;

  always_ff @(posedge clk) begin
    if (rst) begin
      masked <= 1'b1;
    end else if (wr_en && wr_sel == SEL_MASK) begin
      masked <= wr_data[0];
    end else if (last && !auto_init) begin
      masked <= 1'b1;
    end
  end

  dma_addr_ctr #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .PAGE_W(PAGE_W), .HPAGE_W(HPAGE_W)
  ) u_addr (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .step(step), .reload(reload), .word_mode(word_mode),
    .cur_addr(cur_addr), .page(page), .hpage(hpage), .hi32(hi32)
  );

  dma_cnt_unit #(
    .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_cnt (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .step(step), .reload(reload), .word_mode(word_mode),
    .cur_cnt(cur_cnt), .at_zero(at_zero), .tc(tc), .residue(residue)
  );

  dma_addr_map #(
    .CNT_W(CNT_W), .PAGE_W(PAGE_W), .HPAGE_W(HPAGE_W)
  ) u_map (
    .word_mode(word_mode), .cur_addr(cur_addr), .page(page), .hpage(hpage),
    .phys_addr(phys_addr)
  );

  assert_masked_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (xfer && masked && !wr_en) |=> ($stable(cur_cnt) && $stable(cur_addr)));

  assert_stop_masks_R10: assert property (@(posedge clk) disable iff (rst)
    (tc && !$past(auto_init)) |-> masked);

  assert_word_a0_R3: assert property (@(posedge clk) disable iff (rst)
    word_mode |-> (phys_addr[0] == 1'b0));

  assert_hpage_top_R4: assert property (@(posedge clk) disable iff (rst)
    phys_addr[ADDR_W-1 -: HPAGE_W] == hpage);
endmodule

// File: tb/dma_addr_engine_tb.sv
module dma_addr_engine_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = 3'd0;
  logic [7:0]  wr_data = 8'd0;
  logic        xfer = 1'b0;
  logic        word_mode = 1'b0;
  logic        auto_init = 1'b0;
  logic [31:0] phys_addr;
  logic        tc;
  logic [16:0] residue;
  logic        masked;

  always #2 clk = ~clk;

  dma_addr_engine u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .xfer(xfer), .word_mode(word_mode), .auto_init(auto_init),
    .phys_addr(phys_addr), .tc(tc), .residue(residue), .masked(masked)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit started = 0;
  bit done = 0;
  string tag = "R1";

  // behavioural reference state
  int unsigned m_base_a, m_cur_a, m_base_c, m_cur_c, m_page, m_hp;
  bit m_hi32, m_mask, m_tc;

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      m_base_a = 0; m_cur_a = 0; m_base_c = 0; m_cur_c = 0;
      m_page = 0; m_hp = 0; m_hi32 = 0; m_mask = 1; m_tc = 0;
    end else begin
      m_tc = 0;
      if (wr_en) begin
        case (wr_sel)
          3'd0: begin m_base_a = (m_base_a & 32'hFF00) | wr_data; m_cur_a = (m_cur_a & 32'hFF00) | wr_data; end
          3'd1: begin m_base_a = (m_base_a & 32'h00FF) | (wr_data << 8); m_cur_a = (m_cur_a & 32'h00FF) | (wr_data << 8); end
          3'd2: begin m_base_c = (m_base_c & 32'hFF00) | wr_data; m_cur_c = (m_cur_c & 32'hFF00) | wr_data; end
          3'd3: begin m_base_c = (m_base_c & 32'h00FF) | (wr_data << 8); m_cur_c = (m_cur_c & 32'h00FF) | (wr_data << 8); end
          3'd4: begin m_page = wr_data; m_hi32 = 0; end
          3'd5: begin m_hp = wr_data; m_hi32 = 1; end
          3'd6: m_mask = wr_data[0];
          default: ;
        endcase
      end else if (xfer && !m_mask) begin
        bit last;
        last = (m_cur_c == 0);
        if (last && auto_init) begin
          m_cur_a = m_base_a;
          m_cur_c = m_base_c;
        end else begin
          if (m_cur_a == 65535 && m_hi32) begin
            int unsigned pg;
            pg = ((m_hp * 256 + m_page) + (word_mode ? 2 : 1)) % 65536;
            m_hp = pg / 256;
            m_page = pg % 256;
          end
          m_cur_a = (m_cur_a + 1) % 65536;
          m_cur_c = (m_cur_c + 65535) % 65536;
        end
        if (last) begin
          m_tc = 1;
          if (!auto_init) m_mask = 1;
        end
      end
    end
  end

  task automatic check(string t, string what, longint unsigned act, longint unsigned exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", t, what, act, exp, cycles);
    end
  endtask

  function automatic int unsigned exp_addr();
    if (word_mode) return (m_hp << 24) | ((m_page & 32'hFE) << 16) | (m_cur_a << 1);
    return (m_hp << 24) | (m_page << 16) | m_cur_a;
  endfunction

  function automatic int unsigned exp_res();
    return ((m_cur_c + 1) % 65536) * (word_mode ? 2 : 1);
  endfunction

  // compare every output on every clock, away from the active edge
  always @(negedge clk) begin
    if (started && !rst && !done) begin
      check(tag, "phys_addr", phys_addr, exp_addr());
      check("R8", "tc", tc, m_tc);
      check("R9", "residue", residue, exp_res());
      check("R10 R11", "masked", masked, m_mask);
    end
  end

  task automatic cyc(bit we, bit [2:0] s, bit [7:0] d, bit x);
    @(negedge clk);
    #1;
    wr_en = we; wr_sel = s; wr_data = d; xfer = x;
  endtask

  task automatic wr(bit [2:0] s, bit [7:0] d);
    cyc(1'b1, s, d, 1'b0);
  endtask

  task automatic go(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 8'd0, 1'b1);
    cyc(1'b0, 3'd0, 8'd0, 1'b0);
  endtask

  // R12: register load through the select codes
  task automatic load(bit [15:0] a, bit [15:0] c);
    wr(3'd0, a[7:0]); wr(3'd1, a[15:8]);
    wr(3'd2, c[7:0]); wr(3'd3, c[15:8]);
  endtask

  task automatic finish_up();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", "reset masked", masked, 1);
    check("R1", "reset addr", phys_addr, 0);
    check("R1", "reset residue", residue, 1);
    check("R1", "reset tc", tc, 0);

    // R2 R5 R8 R12: byte mode, window wrap, terminal count then masking
    tag = "R2 R5 R12";
    load(16'hFFFE, 16'd3);
    wr(3'd4, 8'h12);
    wr(3'd6, 8'h00);
    go(5);

    // R6 R4: upper page written, carry crosses into page
    tag = "R4 R6";
    load(16'hFFFE, 16'd3);
    wr(3'd5, 8'h34);
    wr(3'd6, 8'h00);
    go(4);

    // R3 R7: word mode, page write drops carry mode, page bit 0 ignored
    tag = "R3 R7";
    word_mode = 1'b1;
    wr(3'd4, 8'h21);
    load(16'hFFFF, 16'd1);
    wr(3'd6, 8'h00);
    go(3);

    // R6 word mode carry adds two to page
    tag = "R3 R6";
    wr(3'd4, 8'h21);
    wr(3'd5, 8'h07);
    load(16'hFFFF, 16'd1);
    wr(3'd6, 8'h00);
    go(3);

    // R10 auto reload, never masks
    tag = "R2 R10";
    word_mode = 1'b0;
    auto_init = 1'b1;
    load(16'h0100, 16'd2);
    wr(3'd6, 8'h00);
    go(7);

    // R11 masked strobes and write-cycle strobes are ignored
    tag = "R11";
    auto_init = 1'b0;
    wr(3'd6, 8'h01);
    go(4);
    wr(3'd6, 8'h00);
    cyc(1'b1, 3'd4, 8'h55, 1'b1);
    go(2);
    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule